// File: doc/BRIEF.md
# Grouped Pin-Change Interrupt Controller

This block watches 27 general-purpose input pins and turns any level change on them, rising or falling, into an interrupt flag for the group the pin belongs to. The pins fall into four groups of uneven size. Three groups hold eight pins each and the last group holds three. Each pin has its own enable bit in a per-group mask. Each group has an enable bit. A flag stays set until one of two things clears it: software writes a one to the flag, or the interrupt handler for that group acknowledges it.

Pins cross into the clock domain through two flip-flop stages. A third register keeps the previous level, and the XOR of the two gives a one-cycle change pulse. A group raises its request when its flag, its group enable and the global interrupt enable are all set. A priority encoder reports the lowest-numbered group with a pending request.

Software reaches the block through a byte-wide register port. Writes are synchronous and reads are combinational. The flag register is at offset 0, the group-enable register at offset 1, and the four mask registers at offsets 2 to 5, one per group in group order.

Top module: `pcint_ctrl`

## Requirements
- R1: After reset, every register offset 0 to 7 reads 0, and no interrupt request or pending indication is active.
- R2: A level change on a pin, rising or falling, sets the flag of the pin's group. This needs the pin's mask bit and the group's enable bit to be 1. The flag is readable in the third cycle after the pin changes: the change is driven before edge 1 and the flag is set at edge 3.
- R3: A pin whose mask bit is 0 never sets its group's flag.
- R4: A group whose enable bit (bit g of offset 1) is 0 never sets its flag, whatever its masks hold.
- R5: Writing offset 0 clears each flag whose data bit is 1 and leaves each flag whose data bit is 0 unchanged.
- R6: A 1 on bit g of the acknowledge input at a clock edge clears the flag of group g.
- R7: If a new change sets a flag in the same cycle that a write-one or an acknowledge clears it, the flag ends the cycle at 1.
- R8: Bit g of the interrupt request output is 1 exactly when flag g, group-enable bit g and the global interrupt-enable input are all 1.
- R9: The pending-valid output is 1 when any request is active. The pending index is then the lowest-numbered requesting group.
- R10: Flag bits 7..4, group-enable bits 7..4 and mask bits 7..3 of group 3 (offset 5) ignore writes and read 0. Offsets 6 and 7 read 0.
- R11: Flag bit 0 covers pins 0–7, bit 1 covers pins 8–15, bit 2 covers pins 16–23 and bit 3 covers pins 24–26. Mask bit b at offset 2+g belongs to pin 8g+b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 27 | Asynchronous input pins |
| gie_i | input | 1 | Global interrupt enable |
| ack_i | input | 4 | Per-group service acknowledge, one cycle |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register offset |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data, combinational in the offset |
| irq_o | output | 4 | Per-group interrupt requests |
| pend_valid_o | output | 1 | Any request active |
| pend_idx_o | output | 2 | Lowest-numbered requesting group |

## Verification
In one cycle a flag can receive both its set, from a detected change, and its clear, from a write of one or an acknowledge. The bench provokes this on purpose. It toggles a pin and then issues the clear exactly two cycles later, so that the clear meets the set at the edge where the change pulse arrives. It then reads the flag back and expects 1. Random traffic also produces the collision many times. There a bench model with its own three-stage pin history judges every cycle: it applies the clear before the set, and uses the mask values that were held before that cycle's write.

// File: rtl/pcint_pkg.sv
package pcint_pkg;

  localparam int unsigned DEF_GROUPS  = 4;
  localparam int unsigned DEF_FULL_W  = 8;
  localparam int unsigned DEF_LAST_W  = 3;
  localparam int unsigned DEF_DATA_W  = 8;
  localparam int unsigned DEF_ADDR_W  = 3;

  localparam int unsigned OFS_FLAG      = 0;
  localparam int unsigned OFS_ENABLE    = 1;
  localparam int unsigned OFS_MASK_BASE = 2;

  function automatic int unsigned grp_width(int unsigned g, int unsigned ng,
                                            int unsigned fw, int unsigned lw);
    return (g == ng - 1) ? lw : fw;
  endfunction

  function automatic int unsigned grp_base(int unsigned g, int unsigned fw);
    return g * fw;
  endfunction

  function automatic int unsigned pin_total(int unsigned ng, int unsigned fw,
                                            int unsigned lw);
    return (ng - 1) * fw + lw;
  endfunction

  function automatic int unsigned idx_width(int unsigned ng);
    return (ng > 1) ? $clog2(ng) : 1;
  endfunction

endpackage

// File: rtl/pcint_pin_sync.sv
module pcint_pin_sync #(
  parameter int unsigned N = 27
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] chg_o
);

  logic [N-1:0] stage1_q;
  logic [N-1:0] stage2_q;
  logic [N-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1_q <= '0;
      stage2_q <= '0;
      prev_q   <= '0;
    end else begin
      stage1_q <= pin_i;
      stage2_q <= stage1_q;
      prev_q   <= stage2_q;
    end
  end

  // one-cycle pulse on either edge of the synchronized level
  assign chg_o = stage2_q ^ prev_q;

endmodule

// File: rtl/pcint_regfile.sv
module pcint_regfile
  import pcint_pkg::*;
#(
  parameter int unsigned NG = DEF_GROUPS,
  parameter int unsigned FW = DEF_FULL_W,
  parameter int unsigned LW = DEF_LAST_W,
  parameter int unsigned DW = DEF_DATA_W,
  parameter int unsigned AW = DEF_ADDR_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [AW-1:0]          addr_i,
  input  logic [DW-1:0]          wdata_i,
  input  logic [NG-1:0]          flags_i,
  output logic [DW-1:0]          rdata_o,
  output logic [NG-1:0]          en_o,
  output logic [NG-1:0][FW-1:0]  mask_o,
  output logic [NG-1:0]          flag_clr_o
);

  logic sel_flag;
  logic sel_en;

  assign sel_flag = (addr_i == AW'(OFS_FLAG));
  assign sel_en   = (addr_i == AW'(OFS_ENABLE));

  // group enables: only NG bits exist
  logic [NG-1:0] en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                en_q <= '0;
    else if (we_i && sel_en)   en_q <= wdata_i[NG-1:0];
  end
  assign en_o = en_q;

  // write-one-to-clear strobe toward the flag logic
  assign flag_clr_o = (we_i && sel_flag) ? wdata_i[NG-1:0] : '0;

  // masks: one register per group, unimplemented bits held at 0
  for (genvar g = 0; g < NG; g++) begin : g_mask
    localparam int unsigned W = grp_width(g, NG, FW, LW);
    localparam logic [FW-1:0] KEEP = {FW{1'b1}} >> (FW - W);
    logic sel_m;
    logic [FW-1:0] m_q;

    assign sel_m = (addr_i == AW'(OFS_MASK_BASE + g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              m_q <= '0;
      else if (we_i && sel_m)  m_q <= wdata_i[FW-1:0] & KEEP;
    end
    assign mask_o[g] = m_q;
  end

  // read mux; undefined offsets return 0
  always_comb begin
    rdata_o = '0;
    if (sel_flag) rdata_o[NG-1:0] = flags_i;
    if (sel_en)   rdata_o[NG-1:0] = en_q;
    for (int unsigned g = 0; g < NG; g++) begin
      if (addr_i == AW'(OFS_MASK_BASE + g)) rdata_o[FW-1:0] = mask_o[g];
    end
  end

endmodule

// File: rtl/pcint_group_flags.sv
module pcint_group_flags
  import pcint_pkg::*;
#(
  parameter int unsigned NG = DEF_GROUPS,
  parameter int unsigned FW = DEF_FULL_W,
  parameter int unsigned LW = DEF_LAST_W,
  localparam int unsigned NP = pin_total(NG, FW, LW)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         chg_i,
  input  logic [NG-1:0][FW-1:0] mask_i,
  input  logic [NG-1:0]         en_i,
  input  logic [NG-1:0]         clr_wr_i,
  input  logic [NG-1:0]         ack_i,
  input  logic                  gie_i,
  output logic [NG-1:0]         hit_o,
  output logic [NG-1:0]         flags_o,
  output logic [NG-1:0]         irq_o
);

  // gather each group's change pulses into a full-width lane
  for (genvar g = 0; g < NG; g++) begin : g_grp
    localparam int unsigned W    = grp_width(g, NG, FW, LW);
    localparam int unsigned BASE = grp_base(g, FW);
    logic [FW-1:0] lane;
    for (genvar b = 0; b < FW; b++) begin : g_bit
      if (b < W) begin : g_live
        assign lane[b] = chg_i[BASE + b];
      end else begin : g_dead
        assign lane[b] = 1'b0;
      end
    end
    assign hit_o[g] = en_i[g] & (|(lane & mask_i[g]));
  end

  logic [NG-1:0] flags_q;
  logic [NG-1:0] clr_any;

  assign clr_any = clr_wr_i | ack_i;

  // set has priority over any clear in the same cycle
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= (flags_q & ~clr_any) | hit_o;
  end

  assign flags_o = flags_q;
  assign irq_o   = flags_q & en_i & {NG{gie_i}};

endmodule

// File: rtl/pcint_prio.sv
module pcint_prio
  import pcint_pkg::*;
#(
  parameter int unsigned NG = DEF_GROUPS,
  localparam int unsigned IW = idx_width(NG)
) (
  input  logic [NG-1:0] req_i,
  output logic          valid_o,
  output logic [IW-1:0] idx_o
);

  function automatic logic [IW-1:0] lowest_set(logic [NG-1:0] v);
    logic [IW-1:0] r;
    r = '0;
    for (int i = NG - 1; i >= 0; i--) begin
      if (v[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign valid_o = |req_i;
  assign idx_o   = lowest_set(req_i);

endmodule

// File: rtl/pcint_ctrl.sv
module pcint_ctrl
  import pcint_pkg::*;
#(
  parameter int unsigned NUM_GROUPS = DEF_GROUPS,
  parameter int unsigned FULL_W     = DEF_FULL_W,
  parameter int unsigned LAST_W     = DEF_LAST_W,
  parameter int unsigned DATA_W     = DEF_DATA_W,
  parameter int unsigned ADDR_W     = DEF_ADDR_W,
  localparam int unsigned NP        = pin_total(NUM_GROUPS, FULL_W, LAST_W),
  localparam int unsigned IW        = idx_width(NUM_GROUPS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NP-1:0]         pin_i,
  input  logic                  gie_i,
  input  logic [NUM_GROUPS-1:0] ack_i,
  input  logic                  reg_we_i,
  input  logic [ADDR_W-1:0]     reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o,
  output logic                  pend_valid_o,
  output logic [IW-1:0]         pend_idx_o
);

  // named internal events, observed by the bound checker
  logic [NP-1:0]                          chg_pulse;
  logic [NUM_GROUPS-1:0]                  grp_hit;
  logic [NUM_GROUPS-1:0]                  grp_flags;
  logic [NUM_GROUPS-1:0]                  grp_en;
  logic [NUM_GROUPS-1:0]                  flag_clr;
  logic [NUM_GROUPS-1:0][FULL_W-1:0]      grp_mask;

  pcint_pin_sync #(.N(NP)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .pin_i (pin_i),
    .chg_o (chg_pulse)
  );

  pcint_regfile #(
    .NG(NUM_GROUPS), .FW(FULL_W), .LW(LAST_W), .DW(DATA_W), .AW(ADDR_W)
  ) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .flags_i    (grp_flags),
    .rdata_o    (reg_rdata_o),
    .en_o       (grp_en),
    .mask_o     (grp_mask),
    .flag_clr_o (flag_clr)
  );

  pcint_group_flags #(
    .NG(NUM_GROUPS), .FW(FULL_W), .LW(LAST_W)
  ) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .chg_i    (chg_pulse),
    .mask_i   (grp_mask),
    .en_i     (grp_en),
    .clr_wr_i (flag_clr),
    .ack_i    (ack_i),
    .gie_i    (gie_i),
    .hit_o    (grp_hit),
    .flags_o  (grp_flags),
    .irq_o    (irq_o)
  );

  pcint_prio #(.NG(NUM_GROUPS)) u_prio (
    .req_i   (irq_o),
    .valid_o (pend_valid_o),
    .idx_o   (pend_idx_o)
  );

endmodule

// File: rtl/pcint_ctrl_chk.sv
module pcint_ctrl_chk #(
  parameter int unsigned NG = 4,
  parameter int unsigned DW = 8,
  parameter int unsigned AW = 3,
  parameter int unsigned IW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie_i,
  input logic [NG-1:0] ack_i,
  input logic [NG-1:0] irq_o,
  input logic          pend_valid_o,
  input logic [IW-1:0] pend_idx_o,
  input logic [NG-1:0] grp_hit,
  input logic [NG-1:0] grp_flags,
  input logic [AW-1:0] reg_addr_i,
  input logic [DW-1:0] reg_rdata_o
);

  for (genvar g = 0; g < NG; g++) begin : g_chk
    // R7: a detected change always leaves the flag set
    p_hit_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
      grp_hit[g] |=> grp_flags[g]);
    // R6: acknowledge without a competing change clears the flag
    p_ack_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i[g] && !grp_hit[g]) |=> !grp_flags[g]);
    // R2: a flag only rises because of a detected change
    p_rise_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(grp_flags[g]) |-> $past(grp_hit[g]));
  end

  p_gie_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !gie_i |-> (irq_o == '0));

  p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o & ~grp_flags) == '0);

  p_pend_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o == (irq_o != '0));

  p_pend_lowest_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_valid_o |-> (irq_o[pend_idx_o] &&
      ((irq_o & ((NG'(1) << pend_idx_o) - NG'(1))) == '0)));

  p_flag_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr_i == AW'(0)) |-> (reg_rdata_o[DW-1:NG] == '0));

endmodule

bind pcint_ctrl pcint_ctrl_chk #(
  .NG(NUM_GROUPS), .DW(DATA_W), .AW(ADDR_W), .IW(IW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .gie_i        (gie_i),
  .ack_i        (ack_i),
  .irq_o        (irq_o),
  .pend_valid_o (pend_valid_o),
  .pend_idx_o   (pend_idx_o),
  .grp_hit      (grp_hit),
  .grp_flags    (grp_flags),
  .reg_addr_i   (reg_addr_i),
  .reg_rdata_o  (reg_rdata_o)
);

// File: tb/tb_pcint_ctrl.sv
`timescale 1ns/1ps
module tb_pcint_ctrl;

  localparam int NP = 27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [NP-1:0] pins  = '0;
  logic          gie   = 1'b0;
  logic [3:0]    ack   = '0;
  logic          we    = 1'b0;
  logic [2:0]    addr  = '0;
  logic [7:0]    wdata = '0;
  wire  [7:0]    rdata;
  wire  [3:0]    irq;
  wire           pv;
  wire  [1:0]    pidx;

  pcint_ctrl dut (
    .clk(clk), .rst_n(rst_n), .pin_i(pins), .gie_i(gie), .ack_i(ack),
    .reg_we_i(we), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .irq_o(irq), .pend_valid_o(pv), .pend_idx_o(pidx)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [NP-1:0] m_s1 = '0, m_s2 = '0, m_prev = '0;
  logic [3:0]    m_flags = '0, m_en = '0;
  logic [7:0]    m_mask [4] = '{default: 8'h00};

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_read(logic [2:0] a);
    case (a)
      3'd0: return {4'h0, m_flags};
      3'd1: return {4'h0, m_en};
      3'd2, 3'd3, 3'd4, 3'd5: return m_mask[a - 3'd2];
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [3:0] exp_irq();
    return m_flags & m_en & {4{gie}};
  endfunction

  function automatic logic [1:0] exp_low(logic [3:0] v);
    if (v[0]) return 2'd0;
    if (v[1]) return 2'd1;
    if (v[2]) return 2'd2;
    return 2'd3;
  endfunction

  // one clock edge of the reference behaviour
  task automatic model_tick();
    logic [NP-1:0] chg;
    logic [3:0] setv, clrv;
    chg = m_s2 ^ m_prev;
    for (int g = 0; g < 4; g++) begin
      int w;
      logic h;
      w = (g == 3) ? 3 : 8;
      h = 1'b0;
      for (int b = 0; b < w; b++) if (chg[8*g + b] && m_mask[g][b]) h = 1'b1;
      setv[g] = h & m_en[g];
    end
    clrv = ack | ((we && addr == 3'd0) ? wdata[3:0] : 4'h0);
    m_flags = (m_flags & ~clrv) | setv;
    if (we && addr == 3'd1) m_en = wdata[3:0];
    if (we && addr >= 3'd2 && addr <= 3'd5)
      m_mask[addr - 3'd2] = wdata & ((addr == 3'd5) ? 8'h07 : 8'hFF);
    m_prev = m_s2;
    m_s2 = m_s1;
    m_s1 = pins;
  endtask

  task automatic step();
    @(posedge clk);
    if (rst_n) model_tick();
    @(negedge clk);
    we  = 1'b0;
    ack = '0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    step();
  endtask

  task automatic rd(logic [2:0] a, logic [7:0] exp, string tag);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic toggle(int p);
    pins[p] = ~pins[p];
    step(); step(); step();
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 8; a++) rd(3'(a), 8'h00, "R1 reset read");
    check("R1 irq", irq, 4'h0);
    check("R1 pending", pv, 1'b0);

    // R10: unused bits ignore writes
    wr(3'd1, 8'hFF); rd(3'd1, 8'h0F, "R10 enable upper bits");
    wr(3'd2, 8'hFF); wr(3'd3, 8'hFF); wr(3'd4, 8'hFF); wr(3'd5, 8'hFF);
    rd(3'd5, 8'h07, "R10 group3 mask");
    rd(3'd6, 8'h00, "R10 offset 6");
    rd(3'd7, 8'h00, "R10 offset 7");
    wr(3'd0, 8'hFF); rd(3'd0, 8'h00, "R10 flag upper bits");

    // R2 and R11: both edges, group mapping
    toggle(24); rd(3'd0, 8'h08, "R11 pin24 to group3 R2 rising");
    wr(3'd0, 8'h08); rd(3'd0, 8'h00, "R5 clear group3");
    toggle(24); rd(3'd0, 8'h08, "R2 falling edge");
    wr(3'd0, 8'h08);
    toggle(7);  rd(3'd0, 8'h01, "R11 pin7 to group0");
    wr(3'd0, 8'h01);
    toggle(8);  rd(3'd0, 8'h02, "R11 pin8 to group1");
    toggle(23); rd(3'd0, 8'h06, "R11 pin23 to group2");

    // R5: write zero keeps, write one clears
    wr(3'd0, 8'h00); rd(3'd0, 8'h06, "R5 write zero keeps");
    wr(3'd0, 8'h02); rd(3'd0, 8'h04, "R5 write one clears");

    // R6: acknowledge clears
    ack = 4'h4; step(); rd(3'd0, 8'h00, "R6 acknowledge");

    // R3: masked pin
    wr(3'd4, 8'hEF); toggle(20); rd(3'd0, 8'h00, "R3 masked pin");
    wr(3'd4, 8'hFF);

    // R4: disabled group
    wr(3'd1, 8'h0D); toggle(9); rd(3'd0, 8'h00, "R4 disabled group");
    check("R4 irq", irq, 4'h0);
    wr(3'd1, 8'h0F);

    // R7: set meets clear in the same cycle
    pins[3] = ~pins[3]; step(); step();
    addr = 3'd0; wdata = 8'h01; we = 1'b1; step();
    rd(3'd0, 8'h01, "R7 set beats write-one");
    pins[3] = ~pins[3]; step(); step();
    ack = 4'h1; step();
    rd(3'd0, 8'h01, "R7 set beats acknowledge");

    // R8: request gating
    gie = 1'b0; #1; check("R8 gie off", irq, 4'h0);
    gie = 1'b1; #1; check("R8 gie on", irq, 4'h1);
    wr(3'd1, 8'h0E); check("R8 enable off", irq, 4'h0);
    wr(3'd1, 8'h0F);

    // R9: lowest group wins
    toggle(26);
    check("R9 irq both", irq, 4'h9);
    check("R9 valid", pv, 1'b1);
    check("R9 lowest", pidx, 2'd0);
    wr(3'd0, 8'h01); check("R9 next", pidx, 2'd3);
    wr(3'd0, 8'h08); check("R9 none", pv, 1'b0);

    // random traffic against the bench model
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] ra;
      pins  = pins ^ (NP'($urandom) & NP'($urandom) & NP'($urandom));
      we    = ($urandom % 4) == 0;
      addr  = 3'($urandom % 8);
      wdata = 8'($urandom);
      ack   = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      gie   = ($urandom % 8) != 0;
      step();
      check("R8 random irq", irq, exp_irq());
      check("R9 random valid", pv, exp_irq() != 4'h0);
      if (exp_irq() != 4'h0) check("R9 random index", pidx, exp_low(exp_irq()));
      ra = 3'($urandom % 8);
      rd(ra, exp_read(ra), "R7 R10 random read");
    end

    done = 1;
    summary();
  end

endmodule